// File: doc/BRIEF.md
# Floating-Point Converter Input Front End

This block sits at the entrance of a digital receive chain. It takes samples from a high-speed converter that reports each sample as a signed mantissa with a small exponent beside it. It turns every sample into a plain two's-complement fixed-point word and sends it to one or two output lanes that feed the mixer after it. A select strobe on every sample tells the block whether it belongs to the first stream or the second.

Three input arrangements are supported. With one real channel, every valid input clock carries a new sample, and that sample goes out on lane A. With one complex channel, in-phase and quadrature samples alternate. With two interleaved real channels (diversity), the two antenna streams alternate. In both alternating modes each stream runs at half the input rate. The block collects the two halves of a pair and releases them on lanes A and B in the same cycle, so later stages can treat both with one coherent timing.

The mode is a strap. It is taken while reset is held and has no effect once reset is released. When the select strobe breaks the expected order, the offending sample is discarded and a sticky error flag is raised.

Top module: `fpInputFront`

## Requirements
- R1: A converted sample equals the 16-bit two's-complement mantissa multiplied by 2 to the power of the 3-bit unsigned exponent, as a 23-bit two's-complement value; no input combination overflows.
- R2: With mode code 0 (single real), and also with the spare code 3, every cycle with inValid high gives outAValid high with the converted sample on outA on the following cycle. outBValid stays low, and inSelA has no effect.
- R3: With mode code 1 (single complex), a sample with inSelA high is the in-phase half and a sample with inSelA low is the quadrature half. After an in-phase sample followed by a quadrature sample, the cycle after the quadrature sample carries outAValid and outBValid both high, with in-phase data on outA and quadrature data on outB.
- R4: With mode code 2 (diversity), inSelA high marks stream A and low marks stream B. An A sample followed by a B sample comes out as one aligned pair on the cycle after the B sample: A on outA, B on outB, both valid flags high together. Idle cycles between the halves are allowed.
- R5: In modes 1 and 2, a sample whose inSelA value does not match the half being waited for is dropped without any output. A held first half is kept, and errFlag goes high on the next cycle.
- R6: errFlag stays high until reset and is cleared by reset.
- R7: modeSel is sampled only while rstN is low. Changes on it after reset is released do not alter behaviour.
- R8: While rstN is low (synchronous, active low), outAValid, outBValid and errFlag are low, and outA and outB are zero.
- R9: A cycle with inValid low produces no output valid flag on the next cycle and does not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; mode is captured while low |
| modeSel | input | 2 | Input arrangement: 0 single real, 1 single complex, 2 diversity, 3 treated as single real |
| inValid | input | 1 | Input sample present this cycle |
| inSelA | input | 1 | High: stream A / in-phase; low: stream B / quadrature |
| inMant | input | 16 | Two's-complement mantissa |
| inExp | input | 3 | Unsigned exponent (left shift amount) |
| outAValid | output | 1 | Lane A carries a new sample |
| outA | output | 23 | Lane A fixed-point sample (real, in-phase or stream A) |
| outBValid | output | 1 | Lane B carries a new sample, always together with lane A |
| outB | output | 23 | Lane B fixed-point sample (quadrature or stream B) |
| errFlag | output | 1 | Sticky out-of-order select error |

## Verification
The bench builds the block with its default widths: a 16-bit mantissa and a 3-bit exponent, which give a 23-bit result. With these widths every exponent from 0 to 7 is exercised, including the full-scale positive and negative mantissas at exponent 7, the two corners where the result fills all 23 bits. The bench reruns the block under all four mode codes. It changes modeSel in the middle of a run to show that the strap is ignored, and it sends misordered selects both before and after a held first half.

// File: rtl/fpInputPkg.sv
package fpInputPkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_CPLX = 2'd1,
    MODE_DIV  = 2'd2,
    MODE_RSVD = 2'd3
  } inMode_t;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic emitSingle;  // pass converted sample straight to lane A
    logic captureA;    // hold converted sample as first half of a pair
    logic emitPair;    // release held half on A and current sample on B
  } pathStrobe_t;

endpackage

// File: rtl/fpScale.sv
module fpScale #(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  localparam int OUT_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [OUT_W-1:0]  fixedVal
);

  logic [OUT_W-1:0] stage [0:EXP_W];

  assign stage[0] = {{(OUT_W-MANT_W){mant[MANT_W-1]}}, mant};

  // one barrel stage per exponent bit, shifting by its binary weight
  for (genvar k = 0; k < EXP_W; k++) begin : gShift
    assign stage[k+1] = expo[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign fixedVal = stage[EXP_W];

endmodule

// File: rtl/fpInputCtrl.sv
module fpInputCtrl
  import fpInputPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        inValid,
  input  logic        inSelA,
  output pathStrobe_t strobe,
  output logic        errFlag
);

  inMode_t modeReg;
  logic    expectB;
  logic    dropNow;
  logic    twoStream;

  assign twoStream = (modeReg == MODE_CPLX) || (modeReg == MODE_DIV);

  always_comb begin
    strobe  = '0;
    dropNow = 1'b0;
    if (inValid) begin
      if (!twoStream) begin
        strobe.emitSingle = 1'b1;
      end else if (!expectB) begin
        if (inSelA) strobe.captureA = 1'b1;
        else        dropNow = 1'b1;
      end else begin
        if (!inSelA) strobe.emitPair = 1'b1;
        else         dropNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= inMode_t'(modeSel);
      expectB <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.captureA) expectB <= 1'b1;
      if (strobe.emitPair) expectB <= 1'b0;
      if (dropNow)         errFlag <= 1'b1;
    end
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeReg));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R2
  real_no_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_REAL || modeReg == MODE_RSVD) |-> !(strobe.captureA || strobe.emitPair));

  // R5
  repeat_a_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && twoStream && expectB && inSelA) |=> errFlag);

endmodule

// File: rtl/fpInputPath.sv
module fpInputPath
  import fpInputPkg::*;
#(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  localparam int OUT_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic [MANT_W-1:0] inMant,
  input  logic [EXP_W-1:0]  inExp,
  output logic              outAValid,
  output logic [OUT_W-1:0]  outA,
  output logic              outBValid,
  output logic [OUT_W-1:0]  outB
);

  logic [OUT_W-1:0] convVal;
  logic [OUT_W-1:0] holdA;

  fpScale #(.MANT_W(MANT_W), .EXP_W(EXP_W)) uScale (
    .mant    (inMant),
    .expo    (inExp),
    .fixedVal(convVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAValid <= 1'b0;
      outBValid <= 1'b0;
      outA      <= '0;
      outB      <= '0;
      holdA     <= '0;
    end else begin
      outAValid <= strobe.emitSingle | strobe.emitPair;
      outBValid <= strobe.emitPair;
      if (strobe.captureA)   holdA <= convVal;
      if (strobe.emitSingle) outA  <= convVal;
      if (strobe.emitPair) begin
        outA <= holdA;
        outB <= convVal;
      end
    end
  end

  // R4
  pair_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    outBValid |-> outAValid);

  // R1
  unit_scale_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emitSingle && inExp == '0) |=>
      (outA == {{(OUT_W-MANT_W){$past(inMant[MANT_W-1])}}, $past(inMant)}));

endmodule

// File: rtl/fpInputFront.sv
module fpInputFront
  import fpInputPkg::*;
#(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  localparam int OUT_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              inValid,
  input  logic              inSelA,
  input  logic [MANT_W-1:0] inMant,
  input  logic [EXP_W-1:0]  inExp,
  output logic              outAValid,
  output logic [OUT_W-1:0]  outA,
  output logic              outBValid,
  output logic [OUT_W-1:0]  outB,
  output logic              errFlag
);

  pathStrobe_t strobe;

  fpInputCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .inValid(inValid),
    .inSelA (inSelA),
    .strobe (strobe),
    .errFlag(errFlag)
  );

  fpInputPath #(.MANT_W(MANT_W), .EXP_W(EXP_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inMant   (inMant),
    .inExp    (inExp),
    .outAValid(outAValid),
    .outA     (outA),
    .outBValid(outBValid),
    .outB     (outB)
  );

endmodule

// File: tb/tb_fpInputFront.sv
`timescale 1ns/1ps
module tb_fpInputFront;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        inValid;
  logic        inSelA;
  logic [15:0] inMant;
  logic [2:0]  inExp;
  logic        outAValid, outBValid, errFlag;
  logic [22:0] outA, outB;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic        bValid;
    logic [22:0] aVal;
    logic [22:0] bVal;
    string       req;
  } expItem_t;

  expItem_t sbQ[$];
  logic [22:0] heldA;

  always #10 clk = ~clk;

  fpInputFront dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .inValid(inValid),
    .inSelA(inSelA), .inMant(inMant), .inExp(inExp),
    .outAValid(outAValid), .outA(outA), .outBValid(outBValid),
    .outB(outB), .errFlag(errFlag)
  );

  function automatic logic [22:0] refConv(logic [15:0] m, logic [2:0] e);
    longint v;
    v = longint'($signed(m)) * (longint'(1) << e);
    return v[22:0];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pop and compare whenever the block emits
  always @(negedge clk) begin
    if (rstN && (outAValid || outBValid)) begin
      if (sbQ.size() == 0) begin
        check(0, "R9", "unexpected output valid", {outAValid, outBValid}, 0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        check(outAValid == 1'b1, it.req, "outAValid", outAValid, 1);
        check(outBValid == it.bValid, it.req, "outBValid", outBValid, it.bValid);
        check(outA == it.aVal, it.req, "outA", outA, it.aVal);
        if (it.bValid) check(outB == it.bVal, it.req, "outB", outB, it.bVal);
      end
    end
  end

  task automatic doReset(logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0; modeSel = m; inValid = 1'b0;
    repeat (2) @(negedge clk);
    // R8 reset state
    check(outAValid == 0 && outBValid == 0, "R8", "valids in reset", {outAValid, outBValid}, 0);
    check(errFlag == 0, "R8", "errFlag in reset", errFlag, 0);
    check(outA == 0 && outB == 0, "R8", "data in reset", outA, 0);
    rstN = 1'b1;
    heldA = '0;
  endtask

  // sends one sample; tag: 0 real, 1 first half, 2 second half, 3 dropped
  task automatic send(bit sel, logic [15:0] m, logic [2:0] e, int tag, string req);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1; inSelA = sel; inMant = m; inExp = e;
    case (tag)
      0: begin it.bValid = 0; it.aVal = refConv(m, e); it.bVal = '0; it.req = req; sbQ.push_back(it); end
      1: heldA = refConv(m, e);
      2: begin it.bValid = 1; it.aVal = heldA; it.bVal = refConv(m, e); it.req = req; sbQ.push_back(it); end
      default: ;
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inMant = 16'hA5A5; inSelA = ~inSelA;
    end
  endtask

  task automatic drained(string req);
    idle(3);
    check(sbQ.size() == 0, req, "items left in scoreboard", sbQ.size(), 0);
  endtask

  initial begin
    #(20 * 20000);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeSel = 2'd0; inValid = 1'b0; inSelA = 1'b0;
    inMant = '0; inExp = '0;

    // ---- single real mode
    doReset(2'd0);
    send(1, 16'h1234, 3'd0, 0, "R1");
    send(0, 16'h7FFF, 3'd7, 0, "R1");
    send(0, 16'h8000, 3'd7, 0, "R1");
    send(1, 16'hFFFF, 3'd3, 0, "R2");
    send(1, 16'h0001, 3'd5, 0, "R2");
    idle(1);
    @(negedge clk);
    // R9: idle cycle gives no valid
    check(outAValid == 0 && outBValid == 0, "R9", "valid after idle", {outAValid, outBValid}, 0);
    // R7: strap change while running is ignored
    modeSel = 2'd2;
    send(0, 16'h0100, 3'd2, 0, "R7");
    send(0, 16'hF000, 3'd1, 0, "R7");
    send(0, 16'h4321, 3'd6, 0, "R7");
    drained("R7");
    check(errFlag == 0, "R7", "errFlag in real mode", errFlag, 0);

    // ---- single complex mode
    doReset(2'd1);
    send(1, 16'h0123, 3'd1, 1, "R3");
    send(0, 16'hFEDC, 3'd2, 2, "R3");
    send(1, 16'h7FFF, 3'd7, 1, "R3");
    send(0, 16'h8000, 3'd7, 2, "R3");
    drained("R3");
    check(errFlag == 0, "R3", "errFlag after good pairs", errFlag, 0);
    // R5: second in-phase sample in a row is dropped, held one kept
    send(1, 16'h1111, 3'd0, 1, "R5");
    send(1, 16'h2222, 3'd0, 3, "R5");
    @(negedge clk);
    inValid = 1'b0;
    check(errFlag == 1, "R5", "errFlag after repeated I", errFlag, 1);
    send(0, 16'h3333, 3'd0, 2, "R5");
    drained("R5");
    send(1, 16'h0AAA, 3'd4, 1, "R6");
    send(0, 16'h0BBB, 3'd4, 2, "R6");
    drained("R6");
    check(errFlag == 1, "R6", "errFlag still set", errFlag, 1);

    // ---- diversity mode
    doReset(2'd2);
    check(errFlag == 0, "R6", "errFlag cleared by reset", errFlag, 0);
    send(1, 16'h4000, 3'd3, 1, "R4");
    idle(2);
    send(0, 16'hC000, 3'd3, 2, "R4");
    send(1, 16'h0005, 3'd0, 1, "R4");
    send(0, 16'h0006, 3'd7, 2, "R4");
    drained("R4");
    // R5: B when A expected is dropped
    send(0, 16'h7777, 3'd1, 3, "R5");
    @(negedge clk);
    inValid = 1'b0;
    check(errFlag == 1, "R5", "errFlag after early B", errFlag, 1);
    send(1, 16'h1357, 3'd2, 1, "R5");
    send(0, 16'h2468, 3'd2, 2, "R5");
    drained("R5");

    // ---- spare code behaves as single real
    doReset(2'd3);
    send(0, 16'h00FF, 3'd1, 0, "R2");
    send(0, 16'h8001, 3'd4, 0, "R2");
    send(1, 16'h0F0F, 3'd0, 0, "R2");
    drained("R2");
    check(errFlag == 0, "R2", "errFlag with spare code", errFlag, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule